// File: doc/BRIEF.md
# Timer Capture/Compare Channel

One channel of a timer block. It works against a free-running counter that lives outside the channel and runs in one of three modes: input capture, output compare, or pulse-width modulation.

In capture mode the channel synchronizes an external pin and watches it for a selected edge. On that edge it latches the counter into its value register. In compare and PWM modes it watches for the counter becoming equal to the value register. It then drives its output pin according to the selected action. Either kind of event sets a status flag. The flag can raise an interrupt request.

Software reaches the channel through an 8-bit control/status register and a separate value register. Software clears the flag in two steps: it reads the control register while the flag reads 1, then writes 0 to the flag bit. If a new event arrives between that read and that write, the write leaves the flag set, so a pending interrupt is never dropped.

Top module: `tmr_chan_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, and the value register, the output pin and the interrupt request are all 0.
- R2: Control layout: bit7 flag, bit6 interrupt enable, bits5:4 mode, bits3:2 edge/action select, bit1 overflow toggle, bit0 full-duty. In capture mode (mode 00) the select code picks the trigger: 01 rising, 10 falling, 11 either edge, 00 no events. After a pin change, the flag reads 1 three clock edges later.
- R3: A capture loads the counter value present at the capturing clock edge into the value register, on the same edge that sets the flag.
- R4: In compare mode (01) and PWM mode (1x), the flag sets on the first clock edge at which the counter equals the value register. A counter that stays equal produces no further event.
- R5: In compare mode a match drives the output according to the select code: 01 toggle, 10 drive low, 11 drive high, 00 leave unchanged. Without a match or an overflow the output holds.
- R6: In compare mode with bit1 set, each counter-overflow pulse toggles the output.
- R7: In PWM mode, select 10 drives the output high on overflow and low on match, and select 01 or 11 does the reverse. Bit0 set holds the output at its overflow level.
- R8: Reading the control register while the flag is 1, then writing bit7 = 0, clears the flag.
- R9: Writing 1 to bit7 never changes the flag. Writing 0 to bit7 with no preceding read that saw the flag at 1 leaves the flag set.
- R10: A new event between the arming read and the clearing write cancels the clear, and the flag stays set.
- R11: The interrupt request equals flag AND interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Shared free-running counter value |
| cnt_ovf_i | input | 1 | One-cycle counter overflow pulse |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| ctl_rd_i | input | 1 | Control register read strobe |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register read data |
| val_wr_i | input | 1 | Value register write strobe |
| val_wdata_i | input | CNT_W | Value register write data |
| cap_val_o | output | CNT_W | Value register (captured or compare value) |
| cmp_pin_o | output | 1 | Compare / PWM output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
A capture result appears on the third rising edge after the pin changes: two synchronizer stages, then the flag register. Compare, PWM and overflow results, as well as the flag and arm updates from register accesses, appear on the first edge after the stimulus.

The driver applies each stimulus just after a rising edge and steps the exact number of edges that the result needs. It then queues the expected value, and the monitor compares the outputs on the following falling edge. The capture timing is also checked one edge early, to catch a flag that appears too soon.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef struct packed {
    logic       flag;
    logic       ie;
    logic [1:0] mode;
    logic [1:0] sel;
    logic       tov;
    logic       maxd;
  } chan_ctl_t;

  localparam logic [1:0] MODE_CAP = 2'b00;
  localparam logic [1:0] MODE_CMP = 2'b01;

  // Trigger decision for one sampled pin transition.
  function automatic logic edge_hit(input logic [1:0] sel, input logic prev, input logic cur);
    case (sel)
      2'b01:   return !prev && cur;
      2'b10:   return prev && !cur;
      2'b11:   return prev ^ cur;
      default: return 1'b0;
    endcase
  endfunction

  // Next output level for compare and PWM modes.
  function automatic logic out_next(input logic [1:0] mode, input logic [1:0] sel,
                                    input logic tov, input logic maxd,
                                    input logic match, input logic ovf, input logic cur);
    logic v;
    logic act;
    v = cur;
    if (mode == MODE_CAP) begin
      v = cur;
    end else if (mode[1]) begin
      act = (sel == 2'b10);
      if (sel != 2'b00) begin
        if (maxd) begin
          v = act;
        end else begin
          if (match) v = !act;
          if (ovf)   v = act;
        end
      end
    end else begin
      if (match) begin
        case (sel)
          2'b01:   v = !cur;
          2'b10:   v = 1'b0;
          2'b11:   v = 1'b1;
          default: v = cur;
        endcase
      end
      if (tov && ovf) v = !v;
    end
    return v;
  endfunction

endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] sel_i,
  output logic       hit_o
);
  import tmr_chan_pkg::*;

  logic [SYNC_N:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_N-1:0], pin_i};
  end

  assign hit_o = edge_hit(sel_i, sh_q[SYNC_N], sh_q[SYNC_N-1]);

  AST_EDGE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 2'b00) |-> !hit_o); // R2

endmodule

// File: rtl/tmr_out_ctl.sv
module tmr_out_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic [1:0] sel_i,
  input  logic       tov_i,
  input  logic       maxd_i,
  input  logic       match_i,
  input  logic       ovf_i,
  output logic       out_o
);
  import tmr_chan_pkg::*;

  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_next(mode_i, sel_i, tov_i, maxd_i, match_i, ovf_i, out_q);
  end

  assign out_o = out_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_i && !ovf_i && !(mode_i[1] && maxd_i)) |=> $stable(out_q)); // R5

endmodule

// File: rtl/tmr_flag_ctl.sv
module tmr_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wr_flag_i,
  output logic flag_o
);
  logic flag_q;
  logic armed_q;
  logic clr_ok;

  assign clr_ok = wr_i && !wr_flag_i && armed_q && !evt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (evt_i)       flag_q <= 1'b1;
      else if (clr_ok) flag_q <= 1'b0;

      if (evt_i || wr_i)       armed_q <= 1'b0;
      else if (rd_i && flag_q) armed_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  AST_CLR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(armed_q && wr_i && !wr_flag_i)); // R8
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> flag_q); // R10
  AST_SET_ONLY_BY_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(evt_i)); // R9

endmodule

// File: rtl/tmr_chan_ctrl.sv
module tmr_chan_ctrl #(
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_ovf_i,
  input  logic             cap_pin_i,
  input  logic             ctl_rd_i,
  input  logic             ctl_wr_i,
  input  logic [7:0]       ctl_wdata_i,
  output logic [7:0]       ctl_rdata_o,
  input  logic             val_wr_i,
  input  logic [CNT_W-1:0] val_wdata_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cmp_pin_o,
  output logic             irq_o
);
  import tmr_chan_pkg::*;

  chan_ctl_t        cfg_q;
  chan_ctl_t        wr_view;
  logic [CNT_W-1:0] val_q;
  logic             match_d;
  logic             match_now;
  logic             match_rise;
  logic             pin_hit;
  logic             cap_evt;
  logic             cmp_evt;
  logic             flag;

  assign wr_view = chan_ctl_t'(ctl_wdata_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (ctl_wr_i) begin
      cfg_q      <= wr_view;
      cfg_q.flag <= 1'b0;
    end
  end

  tmr_edge_det #(.SYNC_N(SYNC_N)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (cap_pin_i),
    .sel_i (cfg_q.sel),
    .hit_o (pin_hit)
  );

  assign match_now  = (cnt_i == val_q);
  assign match_rise = match_now && !match_d;
  assign cap_evt    = (cfg_q.mode == MODE_CAP) && pin_hit;
  assign cmp_evt    = (cfg_q.mode != MODE_CAP) && match_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      match_d <= 1'b0;
    end else begin
      match_d <= match_now;
      if (cap_evt)       val_q <= cnt_i;
      else if (val_wr_i) val_q <= val_wdata_i;
    end
  end

  tmr_flag_ctl u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (cap_evt || cmp_evt),
    .rd_i      (ctl_rd_i),
    .wr_i      (ctl_wr_i),
    .wr_flag_i (ctl_wdata_i[7]),
    .flag_o    (flag)
  );

  tmr_out_ctl u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (cfg_q.mode),
    .sel_i   (cfg_q.sel),
    .tov_i   (cfg_q.tov),
    .maxd_i  (cfg_q.maxd),
    .match_i (cmp_evt),
    .ovf_i   (cnt_ovf_i),
    .out_o   (cmp_pin_o)
  );

  assign ctl_rdata_o = {flag, cfg_q.ie, cfg_q.mode, cfg_q.sel, cfg_q.tov, cfg_q.maxd};
  assign cap_val_o   = val_q;
  assign irq_o       = flag && cfg_q.ie;

  AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_val_o == $past(cnt_i))); // R3
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ctl_rdata_o[7] && ctl_rdata_o[6])); // R11

endmodule

// File: tb/sim_tmr_chan_ctrl.sv
module sim_tmr_chan_ctrl;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt = '0;
  logic         ovf = 1'b0;
  logic         pin = 1'b0;
  logic         rd = 1'b0;
  logic         wr = 1'b0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic         vwr = 1'b0;
  logic [W-1:0] vdata = '0;
  logic [W-1:0] cval;
  logic         opin;
  logic         irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    string tag;
    int    kind;
    int    exp;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  tmr_chan_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_ovf_i(ovf), .cap_pin_i(pin),
    .ctl_rd_i(rd), .ctl_wr_i(wr), .ctl_wdata_i(wdata), .ctl_rdata_o(rdata),
    .val_wr_i(vwr), .val_wdata_i(vdata), .cap_val_o(cval),
    .cmp_pin_o(opin), .irq_o(irq)
  );

  // Monitor: pops queued expectations and compares on the falling edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      int act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = int'(rdata);
        1:       act = int'(irq);
        2:       act = int'(opin);
        default: act = int'(cval);
      endcase
      checks++;
      if (act != it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_v(string tag, int kind, int exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic wr_ctl(logic [7:0] d);
    wr = 1'b1; wdata = d; cyc(); wr = 1'b0;
  endtask

  task automatic rd_ctl();
    rd = 1'b1; cyc(); rd = 1'b0;
  endtask

  task automatic wr_val(logic [W-1:0] d);
    vwr = 1'b1; vdata = d; cyc(); vwr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    expect_v("R1 ctl", 0, 8'h00); expect_v("R1 irq", 1, 0);
    expect_v("R1 out", 2, 0);     expect_v("R1 val", 3, 0);
    settle();

    // R2/R3/R11 rising capture, ie=1
    wr_ctl(8'h44);
    cnt = 16'h1234;
    pin = 1'b1;
    cyc(2);
    expect_v("R2 not yet", 0, 8'h44); settle();
    cyc();
    expect_v("R2 rise flag", 0, 8'hC4); expect_v("R3 captured", 3, 16'h1234);
    expect_v("R11 irq on", 1, 1); settle();

    // R8 clear by read then write 0
    rd_ctl();
    wr_ctl(8'h44);
    expect_v("R8 cleared", 0, 8'h44); expect_v("R11 irq off", 1, 0); settle();

    // R2 falling edge ignored with rising select
    cnt = 16'h2222;
    pin = 1'b0;
    cyc(4);
    expect_v("R2 fall ignored", 0, 8'h44); expect_v("R3 no capture", 3, 16'h1234); settle();

    // R2 falling select
    wr_ctl(8'h48);
    pin = 1'b1; cyc(4);
    expect_v("R2 rise w/ fall sel", 0, 8'h48); settle();
    pin = 1'b0; cyc(3);
    expect_v("R2 fall flag", 0, 8'hC8); expect_v("R3 fall cap", 3, 16'h2222); settle();

    // R9 write 0 without arming read leaves flag set
    wr_ctl(8'h4C);
    cyc();
    expect_v("R9 no arm", 0, 8'hCC); settle();
    rd_ctl(); wr_ctl(8'h4C);
    expect_v("R8 clr2", 0, 8'h4C); settle();
    // R9 write 1 with flag clear has no effect
    wr_ctl(8'hCC);
    expect_v("R9 write1", 0, 8'h4C); settle();

    // R2 any edge, then R10 race
    cnt = 16'h3333;
    pin = 1'b1; cyc(3);
    expect_v("R2 any rise", 0, 8'hCC); settle();
    rd_ctl();                 // armed
    cnt = 16'h4444;
    pin = 1'b0; cyc(3);       // event lands before the write
    expect_v("R3 any fall cap", 3, 16'h4444); settle();
    wr_ctl(8'h4C);
    expect_v("R10 race keeps flag", 0, 8'hCC); expect_v("R10 irq kept", 1, 1); settle();
    rd_ctl(); wr_ctl(8'h4C);
    expect_v("R8 clr3", 0, 8'h4C); settle();

    // R2 select 00 : no events
    wr_ctl(8'h40);
    pin = 1'b1; cyc(4); pin = 1'b0; cyc(4);
    expect_v("R2 sel00", 0, 8'h40); expect_v("R2 sel00 val", 3, 16'h4444); settle();

    // R4/R5 compare, set-high action
    cnt = 16'h0040;
    wr_val(16'h0050);
    wr_ctl(8'h5C);
    cyc();
    expect_v("R5 pre", 2, 0); expect_v("R4 pre", 0, 8'h5C); settle();
    cnt = 16'h0050; cyc();
    expect_v("R4 match flag", 0, 8'hDC); expect_v("R5 set high", 2, 1); settle();
    rd_ctl(); wr_ctl(8'h5C); cyc(2);
    expect_v("R4 held equal no event", 0, 8'h5C); settle();

    // R5 clear action
    wr_ctl(8'h58);
    cnt = 16'h0051; cyc(); cnt = 16'h0050; cyc();
    expect_v("R5 clear low", 2, 0); expect_v("R4 flag again", 0, 8'hD8); settle();
    // R5 toggle action
    wr_ctl(8'hD4);
    cnt = 16'h0051; cyc(); cnt = 16'h0050; cyc();
    expect_v("R5 toggle1", 2, 1); settle();
    cnt = 16'h0051; cyc(); cnt = 16'h0050; cyc();
    expect_v("R5 toggle2", 2, 0); settle();
    // R5 no action
    wr_ctl(8'hD0);
    cnt = 16'h0051; cyc(); cnt = 16'h0050; cyc();
    expect_v("R5 none", 2, 0); settle();

    // R6 overflow toggle
    wr_ctl(8'hD2);
    cnt = 16'h0060;
    ovf = 1'b1; cyc(); ovf = 1'b0;
    expect_v("R6 ovf toggle", 2, 1); settle();
    cyc(2);
    expect_v("R6 hold", 2, 1); settle();
    ovf = 1'b1; cyc(); ovf = 1'b0;
    expect_v("R6 ovf toggle2", 2, 0); settle();
    rd_ctl(); wr_ctl(8'h12);
    expect_v("R8 clr4", 0, 8'h12); settle();

    // R7 PWM select 10, ie=0
    wr_ctl(8'h28);
    cnt = 16'h0010;
    wr_val(16'h0080);
    ovf = 1'b1; cyc(); ovf = 1'b0;
    expect_v("R7 ovf high", 2, 1); settle();
    cnt = 16'h0080; cyc();
    expect_v("R7 match low", 2, 0); expect_v("R4 pwm flag", 0, 8'hA8);
    expect_v("R11 ie0 no irq", 1, 0); settle();
    // R7 PWM select 01
    wr_ctl(8'hA4);
    cnt = 16'h0010;
    ovf = 1'b1; cyc(); ovf = 1'b0;
    expect_v("R7 inv ovf low", 2, 0); settle();
    cnt = 16'h0080; cyc();
    expect_v("R7 inv match high", 2, 1); settle();
    // R7 full duty holds overflow level (low for select 01)
    wr_ctl(8'hA5);
    cyc();
    expect_v("R7 maxd force", 2, 0); settle();
    cnt = 16'h0010; cyc(); cnt = 16'h0080; cyc();
    expect_v("R7 maxd match", 2, 0); settle();

    cyc(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule